// File: doc/BRIEF.md
# DRAM Retention Test Engine

This block measures how long DRAM cells keep their contents once refresh has stopped. A run begins with a start pulse. The engine stops refresh, writes a known word to every location in a programmed address window, and waits a programmed number of cycles. It then reads the window back one word at a time, with a programmed gap between reads, and compares each word with the value it wrote. Mismatches are counted. The first failing address and the word read from it are kept for inspection.

The window bounds, the scan start address, the data word, a checkerboard option, the hold delay and the read gap are all sampled at the start pulse. A run can therefore be repeated with other settings, so that failures can be mapped by cell position and by data polarity. The engine drives a plain memory request port: a one-cycle write strobe, a one-cycle read strobe and a read-valid return. It keeps one read outstanding at a time.

Top module: `retn_engine`

## Requirements
- R1: A start pulse writes each address in the inclusive window [cfg_base, cfg_last] exactly once. Writes go one per cycle, in ascending order from cfg_first, and wrap from cfg_last back to cfg_base. Addresses outside the window are never written.
- R2: The written word is cfg_pattern. When cfg_alt is 1, addresses whose bit 0 is 1 receive the bitwise inverse of cfg_pattern instead.
- R3: Between the final write cycle and the first read request there are exactly cfg_hold+1 cycles with neither strobe asserted.
- R4: Reads cover the window once, in the same address order as the writes. After each read-valid cycle there are exactly cfg_pace+1 idle cycles before the next read request.
- R5: Each returned word that differs from the word written at that address adds one to err_count. At its all-ones value the count saturates instead of wrapping.
- R6: The first mismatch in scan order latches its address into first_addr and its raw read data into first_data, and sets first_valid. Later mismatches leave all three unchanged.
- R7: refresh_off is high from the cycle after the start pulse through the final read response, covering every strobe. It is low while idle or done.
- R8: done rises in the cycle after the final read response. It stays high until the next start pulse, and that pulse also clears err_count and first_valid.
- R9: Configuration inputs and start pulses that arrive while a run is in progress have no effect on that run.
- R10: After reset, all outputs are 0.
- R11: mem_we and mem_re are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; accepted only when idle or done |
| cfg_base | input | AW | Lowest address of the window |
| cfg_last | input | AW | Highest address of the window |
| cfg_first | input | AW | First address scanned, within the window |
| cfg_pattern | input | DW | Data word written |
| cfg_alt | input | 1 | Invert the word at odd addresses |
| cfg_hold | input | TW | Hold delay before read-back, in cycles (plus one) |
| cfg_pace | input | TW | Gap between reads, in cycles (plus one) |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_addr | output | AW | Request address |
| mem_wdata | output | DW | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| refresh_off | output | 1 | Request to the refresh scheduler to stop refreshing |
| done | output | 1 | Run complete; sticky until next start |
| err_count | output | ECW | Saturating mismatch count |
| first_valid | output | 1 | A mismatch has been recorded |
| first_addr | output | AW | Address of the first mismatch |
| first_data | output | DW | Read data at the first mismatch |

## Verification
A wrong scan pointer appears at mem_addr within one cycle, as a skipped, repeated or out-of-window write in the write phase. A timer loaded with the wrong value shows up as a read strobe one or more cycles early or late. An error logger that compares against the wrong expected word shows up only after done, in err_count and first_addr. The bench therefore injects corruption at chosen cells and checks these outputs at the end of every run. A remaining-count error shows as done rising early or late, and the read sequence then comes out shorter or longer than the window.

// File: rtl/retn_pkg.sv
package retn_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_HOLD,
    ST_RDREQ,
    ST_RDWAIT,
    ST_PACE,
    ST_DONE
  } retn_state_e;
endpackage

// File: rtl/retn_addr_walk.sv
module retn_addr_walk #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] load_addr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic [AW-1:0] addr
);
  function automatic logic [AW-1:0] advance(input logic [AW-1:0] a,
                                            input logic [AW-1:0] b,
                                            input logic [AW-1:0] t);
    return (a == t) ? b : a + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_addr;
    else if (step) addr <= advance(addr, lo, hi);
  end
endmodule

// File: rtl/retn_pattern.sv
module retn_pattern #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] pattern,
  input  logic          alt,
  input  logic          odd,
  output logic [DW-1:0] word
);
  function automatic logic [DW-1:0] cell_word(input logic [DW-1:0] p,
                                              input logic alt_en,
                                              input logic is_odd);
    return (alt_en && is_odd) ? ~p : p;
  endfunction

  assign word = cell_word(pattern, alt, odd);
endmodule

// File: rtl/retn_err_log.sv
module retn_err_log #(
  parameter int AW  = 10,
  parameter int DW  = 16,
  parameter int ECW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           cmp_en,
  input  logic [DW-1:0]  rdata,
  input  logic [DW-1:0]  expect_word,
  input  logic [AW-1:0]  addr,
  output logic           mismatch,
  output logic [ECW-1:0] err_count,
  output logic           first_valid,
  output logic [AW-1:0]  first_addr,
  output logic [DW-1:0]  first_data
);
  function automatic logic [ECW-1:0] sat_inc(input logic [ECW-1:0] c);
    return (&c) ? c : c + ECW'(1);
  endfunction

  assign mismatch = cmp_en && (rdata != expect_word);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_count   <= '0;
      first_valid <= 1'b0;
      first_addr  <= '0;
      first_data  <= '0;
    end else if (clear) begin
      err_count   <= '0;
      first_valid <= 1'b0;
    end else if (mismatch) begin
      err_count <= sat_inc(err_count);
      if (!first_valid) begin
        first_valid <= 1'b1;
        first_addr  <= addr;
        first_data  <= rdata;
      end
    end
  end
endmodule

// File: rtl/retn_engine.sv
module retn_engine #(
  parameter int AW  = 10,
  parameter int DW  = 16,
  parameter int TW  = 16,
  parameter int ECW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW-1:0]  cfg_base,
  input  logic [AW-1:0]  cfg_last,
  input  logic [AW-1:0]  cfg_first,
  input  logic [DW-1:0]  cfg_pattern,
  input  logic           cfg_alt,
  input  logic [TW-1:0]  cfg_hold,
  input  logic [TW-1:0]  cfg_pace,
  output logic           mem_we,
  output logic           mem_re,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_rvalid,
  input  logic [DW-1:0]  mem_rdata,
  output logic           refresh_off,
  output logic           done,
  output logic [ECW-1:0] err_count,
  output logic           first_valid,
  output logic [AW-1:0]  first_addr,
  output logic [DW-1:0]  first_data
);
  import retn_pkg::*;

  localparam int LW = AW + 1;

  function automatic logic [LW-1:0] span(input logic [AW-1:0] lo,
                                         input logic [AW-1:0] hi);
    return {1'b0, hi} - {1'b0, lo} + LW'(1);
  endfunction

  retn_state_e   state_q;
  logic [AW-1:0] base_q, last_q, first_q;
  logic [DW-1:0] pat_q;
  logic          alt_q;
  logic [TW-1:0] hold_q, pace_q;
  logic [LW-1:0] left_q;
  logic [TW-1:0] tmr_q;

  // named internal events
  wire launch    = start && (state_q == ST_IDLE || state_q == ST_DONE);
  wire last_item = (left_q == LW'(1));
  wire fill_end  = (state_q == ST_FILL) && last_item;
  wire rsp_ok    = (state_q == ST_RDWAIT) && mem_rvalid;
  wire scan_end  = rsp_ok && last_item;
  wire tmr_zero  = (tmr_q == '0);
  wire walk_step = ((state_q == ST_FILL) || rsp_ok) && !last_item;

  logic [AW-1:0] walk_addr;
  logic [DW-1:0] cell_word;
  logic          mismatch;

  retn_addr_walk #(.AW(AW)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .load(launch || fill_end), .step(walk_step),
    .load_addr(launch ? cfg_first : first_q),
    .lo(base_q), .hi(last_q), .addr(walk_addr)
  );

  retn_pattern #(.DW(DW)) u_pat (
    .pattern(pat_q), .alt(alt_q), .odd(walk_addr[0]), .word(cell_word)
  );

  retn_err_log #(.AW(AW), .DW(DW), .ECW(ECW)) u_log (
    .clk(clk), .rst_n(rst_n), .clear(launch), .cmp_en(rsp_ok),
    .rdata(mem_rdata), .expect_word(cell_word), .addr(walk_addr),
    .mismatch(mismatch), .err_count(err_count), .first_valid(first_valid),
    .first_addr(first_addr), .first_data(first_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0; last_q <= '0; first_q <= '0;
      pat_q  <= '0; alt_q  <= 1'b0;
      hold_q <= '0; pace_q <= '0;
    end else if (launch) begin
      base_q <= cfg_base;    last_q <= cfg_last; first_q <= cfg_first;
      pat_q  <= cfg_pattern; alt_q  <= cfg_alt;
      hold_q <= cfg_hold;    pace_q <= cfg_pace;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      tmr_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: if (launch) begin
          state_q <= ST_FILL;
          left_q  <= span(cfg_base, cfg_last);
        end
        ST_FILL: if (last_item) begin
          state_q <= ST_HOLD;
          left_q  <= span(base_q, last_q);
          tmr_q   <= hold_q;
        end else begin
          left_q <= left_q - LW'(1);
        end
        ST_HOLD, ST_PACE: if (tmr_zero) state_q <= ST_RDREQ;
                          else tmr_q <= tmr_q - TW'(1);
        ST_RDREQ: state_q <= ST_RDWAIT;
        ST_RDWAIT: if (rsp_ok) begin
          left_q <= left_q - LW'(1);
          tmr_q  <= pace_q;
          state_q <= scan_end ? ST_DONE : ST_PACE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_we      = (state_q == ST_FILL);
  assign mem_re      = (state_q == ST_RDREQ);
  assign mem_addr    = walk_addr;
  assign mem_wdata   = cell_word;
  assign refresh_off = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done        = (state_q == ST_DONE);
endmodule

// File: rtl/retn_engine_chk.sv
module retn_engine_chk #(
  parameter int AW  = 10,
  parameter int ECW = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           mem_we,
  input logic           mem_re,
  input logic [AW-1:0]  mem_addr,
  input logic           refresh_off,
  input logic           done,
  input logic [ECW-1:0] err_count,
  input logic           first_valid,
  input logic [AW-1:0]  first_addr,
  input logic [AW-1:0]  base_q,
  input logic [AW-1:0]  last_q
);
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R11
  AST_REFRESH_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> refresh_off); // R7
  AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |-> (mem_addr >= base_q && mem_addr <= last_q)); // R1
  AST_ERR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> err_count >= $past(err_count)); // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R8
  AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (first_valid && !start) |=> (first_valid && $stable(first_addr))); // R6
endmodule

bind retn_engine retn_engine_chk #(.AW(AW), .ECW(ECW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .mem_we(mem_we), .mem_re(mem_re),
  .mem_addr(mem_addr), .refresh_off(refresh_off), .done(done),
  .err_count(err_count), .first_valid(first_valid), .first_addr(first_addr),
  .base_q(base_q), .last_q(last_q)
);

// File: tb/sim_retn_engine.sv
module sim_retn_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4, DW = 8, TW = 4, ECW = 3;
  localparam int DEPTH = 1 << AW;
  localparam int EMAX = (1 << ECW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] cfg_base = '0, cfg_last = '0, cfg_first = '0;
  logic [DW-1:0] cfg_pattern = '0;
  logic cfg_alt = 1'b0;
  logic [TW-1:0] cfg_hold = '0, cfg_pace = '0;
  logic mem_we, mem_re, refresh_off, done, first_valid;
  logic [AW-1:0] mem_addr, first_addr;
  logic [DW-1:0] mem_wdata, first_data;
  logic [ECW-1:0] err_count;
  logic mem_rvalid = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] flip [DEPTH];
  logic p1_v = 1'b0;
  logic [DW-1:0] p1_d = '0;

  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  retn_engine #(.AW(AW), .DW(DW), .TW(TW), .ECW(ECW)) u0 (.*);

  // memory model: two-cycle read latency, flip mask models lost charge
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    p1_v <= mem_re;
    p1_d <= mem[mem_addr] ^ flip[mem_addr];
    mem_rvalid <= p1_v;
    mem_rdata  <= p1_d;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_word(input int a, input int pat, input bit alt);
    int w = pat & 8'hFF;
    if (alt && (a % 2 == 1)) w = w ^ 8'hFF;
    return w;
  endfunction

  task automatic run(input int b, input int l, input int f, input int pat,
                     input bit alt, input int hold, input int pace, input bit disturb);
    int n, wr_n, rd_n, gap, pg, errs, fa, fd, exp_err;
    bit seen_we, first_rd, armed, rf_bad, hold_bad, pace_bad, fv;
    int wr_a[DEPTH], wr_d[DEPTH], rd_a[DEPTH];
    n = l - b + 1;
    wr_n = 0; rd_n = 0; gap = 0; pg = 0; seen_we = 0; first_rd = 1; armed = 0;
    rf_bad = 0; hold_bad = 0; pace_bad = 0;
    for (int a = 0; a < DEPTH; a++) mem[a] = DW'(8'hA5 ^ a);
    cfg_base = AW'(b); cfg_last = AW'(l); cfg_first = AW'(f);
    cfg_pattern = DW'(pat); cfg_alt = alt; cfg_hold = TW'(hold); cfg_pace = TW'(pace);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int cyc = 0; cyc < 3000 && !done; cyc++) begin
      if (!refresh_off) rf_bad = 1;
      if (mem_we) begin
        if (wr_n < DEPTH) begin wr_a[wr_n] = int'(mem_addr); wr_d[wr_n] = int'(mem_wdata); end
        wr_n++; gap = 0; seen_we = 1;
      end else if (mem_re) begin
        if (rd_n < DEPTH) rd_a[rd_n] = int'(mem_addr);
        rd_n++;
        if (first_rd && gap != hold + 1) hold_bad = 1;
        if (armed && pg != pace + 1) pace_bad = 1;
        first_rd = 0; armed = 0;
      end else if (mem_rvalid) begin
        armed = 1; pg = 0;
      end else begin
        if (seen_we && first_rd) gap++;
        if (armed) pg++;
      end
      if (disturb && cyc == 6) begin
        start = 1'b1; cfg_pattern = ~DW'(pat); cfg_base = '0; cfg_last = '1; cfg_alt = ~alt;
      end
      if (disturb && cyc == 7) start = 1'b0;
      @(negedge clk);
    end
    chk(done == 1'b1, "R8 done reached", int'(done), 1);
    chk(wr_n == n, disturb ? "R9 write count" : "R1 write count", wr_n, n);
    chk(rd_n == n, "R4 read count", rd_n, n);
    for (int i = 0; i < n && i < wr_n && i < DEPTH; i++) begin
      int ea = b + ((f - b + i) % n);
      chk(wr_a[i] == ea, "R1 write order", wr_a[i], ea);
      chk(wr_d[i] == exp_word(ea, pat, alt), disturb ? "R9 write data" : "R2 write data",
          wr_d[i], exp_word(ea, pat, alt));
      if (i < rd_n) chk(rd_a[i] == ea, "R4 read order", rd_a[i], ea);
    end
    for (int a = 0; a < DEPTH; a++) begin
      int e = (a >= b && a <= l) ? exp_word(a, pat, alt) : ((8'hA5 ^ a) & 8'hFF);
      chk(int'(mem[a]) == e, "R1 memory image", int'(mem[a]), e);
    end
    chk(!hold_bad, "R3 hold gap", int'(hold_bad), 0);
    chk(!pace_bad, "R4 pace gap", int'(pace_bad), 0);
    chk(!rf_bad, "R7 refresh off during run", int'(rf_bad), 0);
    errs = 0; fv = 0; fa = 0; fd = 0;
    for (int i = 0; i < n; i++) begin
      int ea = b + ((f - b + i) % n);
      if (flip[ea] != '0) begin
        errs++;
        if (!fv) begin fv = 1; fa = ea; fd = exp_word(ea, pat, alt) ^ int'(flip[ea]); end
      end
    end
    exp_err = (errs > EMAX) ? EMAX : errs;
    chk(int'(err_count) == exp_err, "R5 error count", int'(err_count), exp_err);
    chk(first_valid == fv, "R6 first valid", int'(first_valid), int'(fv));
    if (fv) begin
      chk(int'(first_addr) == fa, "R6 first address", int'(first_addr), fa);
      chk(int'(first_data) == fd, "R6 first data", int'(first_data), fd);
    end
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R8 done sticky", int'(done), 1);
    chk(refresh_off == 1'b0, "R7 refresh restored", int'(refresh_off), 0);
    chk(int'(err_count) == exp_err, "R5 count held", int'(err_count), exp_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) begin mem[a] = '0; flip[a] = '0; end
    repeat (3) @(negedge clk);
    chk(done == 0 && refresh_off == 0 && mem_we == 0 && mem_re == 0, "R10 reset controls",
        int'({done, refresh_off, mem_we, mem_re}), 0);
    chk(err_count == 0 && first_valid == 0, "R10 reset log", int'(err_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_we == 0 && mem_re == 0, "R11 idle strobes", int'({mem_we, mem_re}), 0);

    run(0, 15, 0, 8'h5A, 0, 0, 0, 0);
    flip[4] = 8'h01; flip[9] = 8'h80;
    run(3, 12, 7, 8'h3C, 1, 3, 2, 0);
    for (int a = 0; a < DEPTH; a++) flip[a] = '0;
    flip[5] = 8'h10;
    run(5, 5, 5, 8'hA5, 1, 15, 15, 0);
    for (int a = 0; a < DEPTH; a++) flip[a] = DW'(a + 1);
    run(0, 15, 15, 8'hC3, 1, 1, 0, 0);
    for (int a = 0; a < DEPTH; a++) flip[a] = '0;
    flip[8] = 8'h0F;
    run(2, 9, 2, 8'h66, 0, 2, 1, 1);
    for (int f = 0; f < DEPTH; f++) begin
      for (int a = 0; a < DEPTH; a++) flip[a] = '0;
      flip[(f * 5) % DEPTH] = 8'h40;
      flip[(f * 3 + 1) % DEPTH] = 8'h02;
      run(0, 15, f, 8'h55 ^ f, f % 2, f % 4, f % 3, 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule